// File: doc/BRIEF.md
# Transmit Buffer Status and Interrupt Unit

This unit sits between a host and the symbol transmitter of a four-level FSK modem. It keeps track of a single transmit data buffer and tells the host when that buffer may be reloaded and when the transmitter has run dry. The host writes a mode word and task words through a small write port, and it reads a four-bit status word. The unit holds a small transmitter stub that spends a fixed number of symbol ticks on every byte that a task names. While the stub has no data to send, it emits an idle "S" symbol on every tick.

Two status bits describe the buffer. The free flag means a new task may be written. The drained flag means every queued symbol has left the transmitter. They are kept apart because the buffer is freed as soon as its contents move into the transmitter, which is well before those symbols are sent. A third bit, the S-ready flag, marks that an idle symbol has been sent. A sticky interrupt flag drives the interrupt output. A status read clears both the interrupt flag and the S-ready flag.

Top module: `modem_status_irq`

## Requirements
- R1: After reset the buffer-free and drained flags are 1, the S-ready and interrupt flags are 0, the interrupt output is low, the mode word is 0 and `s_sym` is 0.
- R2: A task write (`wr_en`=1, `wr_sel`=1) whose byte count `wr_data` is nonzero, made while the buffer is free, clears the buffer-free and drained flags on the next cycle. A task write with a count of 0, or one made while the buffer is not free, changes nothing.
- R3: A loaded buffer moves into the transmitter on the first `sym_tick` at which the transmitter holds at most one remaining symbol. The buffer-free flag is 1 from the following cycle. If mode bit 0 (interrupt enable) is 1, the interrupt flag is also set.
- R4: A transferred buffer of N bytes occupies the transmitter for 4*N symbol ticks. On the tick that sends its last symbol with no buffer waiting, the drained flag becomes 1. If mode bit 0 is 1, the interrupt flag is set.
- R5: The drained flag stays 0 while the transmitter still holds symbols, even when the buffer-free flag is already 1.
- R6: A `sym_tick` that finds the transmitter empty and no buffer loaded sends an S symbol. `s_sym` then shows the value of mode bits [3:2] at that tick. If mode bit 1 (S-symbol interrupt enable) is 1, the S-ready flag is set, and the interrupt flag is set too when mode bit 0 is also 1.
- R7: `status` = {interrupt, S-ready, drained, buffer-free} in bits 3..0 and shows the value before any clear. A cycle with `rd_en`=1 clears the interrupt and S-ready flags and leaves the other two flags unchanged. A set event in the same cycle wins over the clear.
- R8: With mode bit 0 at 0, no buffer or symbol event sets the interrupt flag. `irq` always equals the interrupt flag.
- R9: A mode write (`wr_en`=1, `wr_sel`=0) loads `wr_data[3:0]` as the mode word. A change to mode bits [3:2] takes effect at the next S symbol sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_tick | input | 1 | One-cycle strobe per symbol period |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0 selects the mode word, 1 selects a task |
| wr_data | input | CNT_W | Mode bits or task byte count |
| rd_en | input | 1 | Status read strobe (clears the interrupt and S-ready flags) |
| status | output | 4 | {irq flag, S-ready, drained, buffer-free} |
| irq | output | 1 | Active-high interrupt request |
| s_sym | output | 2 | Value of the last S symbol sent |

## Verification
Directed runs first walk through a complete frame. A one-byte task is loaded, transferred and drained, which separates the moment the buffer is freed from the moment the transmitter drains. A zero-count task and a task written while the buffer is full are then sent to confirm that both are ignored. Idle ticks are run with the S-symbol interrupt enabled and with the main interrupt enable off. These show that S-ready and the interrupt are gated independently, and that a select change reaches only the next S symbol. A long random phase follows, with random ticks, task writes, reads and mode changes. Every cycle is compared against a reference model, which catches the rarer overlaps: a read in the same cycle as an event, a task accepted on the tick that drains the transmitter, and a buffer that loads on the final symbol of the one before it.

// File: rtl/modem_status_irq.sv
module modem_status_irq #(
  parameter int CNT_W        = 5,
  parameter int SYM_PER_BYTE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_tick,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [3:0]       status,
  output logic             irq,
  output logic [1:0]       s_sym
);
  localparam int ACT_W = CNT_W + $clog2(SYM_PER_BYTE) + 1;

  logic [3:0]       mode;
  logic             buf_full, ibempty, srdy, irq_q;
  logic [ACT_W-1:0] buf_syms, act_cnt;

  wire irq_en  = mode[0];
  wire s_en    = mode[1];
  wire task_wr = wr_en & wr_sel & ~buf_full & (|wr_data);
  wire ev_load = sym_tick & (act_cnt <= ACT_W'(1)) & buf_full;
  wire ev_done = sym_tick & (act_cnt == ACT_W'(1)) & ~buf_full;
  wire ev_s    = sym_tick & (act_cnt == '0) & ~buf_full;
  wire set_irq = irq_en & (ev_load | ev_done | (ev_s & s_en));

  assign status = {irq_q, srdy, ibempty, ~buf_full};
  assign irq    = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= '0;
      buf_full <= 1'b0;
      buf_syms <= '0;
      act_cnt  <= '0;
      ibempty  <= 1'b1;
      srdy     <= 1'b0;
      irq_q    <= 1'b0;
      s_sym    <= '0;
    end else begin
      if (wr_en && !wr_sel) mode <= wr_data[3:0];
      if (task_wr) begin
        buf_full <= 1'b1;
        buf_syms <= ACT_W'(wr_data) * ACT_W'(SYM_PER_BYTE);
      end else if (ev_load) begin
        buf_full <= 1'b0;
      end
      if (ev_load)                        act_cnt <= buf_syms;
      else if (sym_tick && act_cnt != '0) act_cnt <= act_cnt - ACT_W'(1);
      if (task_wr)      ibempty <= 1'b0;
      else if (ev_done) ibempty <= 1'b1;
      if (ev_s) s_sym <= mode[3:2];
      if (ev_s && s_en) srdy <= 1'b1;
      else if (rd_en)   srdy <= 1'b0;
      if (set_irq)    irq_q <= 1'b1;
      else if (rd_en) irq_q <= 1'b0;
    end
  end

  p_task_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && status[0] && wr_data != '0) |=> (!status[0] && !status[1]));

  p_drained_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> (act_cnt == '0 && status[0]));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sym_tick) |=> (!irq && !status[2]));

  p_read_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sym_tick && !wr_en) |=> ($stable(status[0]) && $stable(status[1])));

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(irq)) |-> $past(mode[0]));

  p_srdy_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !$past(status[2])) |-> ($past(mode[1]) && $past(sym_tick)));
endmodule

// File: tb/modem_status_irq_bench.sv
module modem_status_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_tick = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic [3:0] status;
  logic       irq;
  logic [1:0] s_sym;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  modem_status_irq u_modem_status_irq (
    .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .status(status), .irq(irq), .s_sym(s_sym));

  // reference model built from the requirements
  logic [3:0] m_mode;
  logic       m_buf, m_ibe, m_srdy, m_irq;
  int         m_bsyms, m_act;
  logic [1:0] m_ssym;

  always @(posedge clk) begin
    logic acc, eb, ei, es;
    if (!rst_n) begin
      m_mode = 0; m_buf = 0; m_ibe = 1; m_srdy = 0; m_irq = 0;
      m_bsyms = 0; m_act = 0; m_ssym = 0;
    end else begin
      acc = wr_en && wr_sel && !m_buf && wr_data != 0;
      eb = 0; ei = 0; es = 0;
      if (sym_tick) begin
        if (m_buf && m_act <= 1) eb = 1;
        else if (!m_buf && m_act == 1) ei = 1;
        else if (!m_buf && m_act == 0) es = 1;
      end
      if (es) m_ssym = m_mode[3:2];
      if (es && m_mode[1]) m_srdy = 1; else if (rd_en) m_srdy = 0;
      if (m_mode[0] && (eb || ei || (es && m_mode[1]))) m_irq = 1;
      else if (rd_en) m_irq = 0;
      if (eb) begin m_act = m_bsyms; m_buf = 0; end
      else if (sym_tick && m_act > 0) m_act = m_act - 1;
      if (acc) begin m_buf = 1; m_bsyms = 4 * int'(wr_data); m_ibe = 0; end
      else if (ei) m_ibe = 1;
      if (wr_en && !wr_sel) m_mode = wr_data[3:0];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(status[0] == !m_buf, "R3 buffer-free", status[0], !m_buf);
    chk(status[1] == m_ibe,  "R4 drained",     status[1], m_ibe);
    chk(status[2] == m_srdy, "R6 s-ready",     status[2], m_srdy);
    chk(status[3] == m_irq,  "R7 irq flag",    status[3], m_irq);
    chk(irq == m_irq,        "R8 irq pin",     irq, m_irq);
    chk(s_sym == m_ssym,     "R9 s symbol",    s_sym, m_ssym);
  endtask

  task automatic step(input bit t, input bit we, input bit sel, input int d, input bit rd);
    sym_tick = t; wr_en = we; wr_sel = sel; wr_data = 5'(d); rd_en = rd;
    @(negedge clk);
    sym_tick = 0; wr_en = 0; rd_en = 0;
    compare();
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd929));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(status == 4'b0011, "R1 reset status", status, 3);
    chk(irq == 0 && s_sym == 0, "R1 reset outputs", {irq, s_sym}, 0);
    step(0, 1, 0, 5'b00001, 0);                 // mode: irq enable only
    step(0, 1, 1, 0, 0);                        // zero count task
    chk(status == 4'b0011, "R2 zero count ignored", status, 3);
    step(0, 1, 1, 1, 0);                        // one byte
    chk(status == 4'b0000, "R2 task clears flags", status, 0);
    step(0, 1, 1, 7, 0);                        // buffer full: ignored
    step(1, 0, 0, 0, 0);                        // load
    chk(status == 4'b1001, "R3 free and irq after load", status, 9);
    chk(status[1] == 0, "R5 drained held low", status[1], 0);
    step(0, 0, 0, 0, 1);
    chk(status == 4'b0001, "R7 read clears irq only", status, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
    chk(status == 4'b0001, "R5 drained low with symbols left", status, 1);
    step(1, 0, 0, 0, 0);
    chk(status == 4'b1011, "R4 drained after 4 ticks", status, 11);
    step(0, 0, 0, 0, 1);
    step(0, 1, 0, 5'b01011, 0);                 // sel=2, s_en, irq_en
    step(1, 0, 0, 0, 0);
    chk(s_sym == 2 && status == 4'b1111, "R6 S symbol sets srdy/irq", {s_sym, status}, 47);
    step(0, 1, 0, 5'b00110, 1);                 // sel=1, s_en, irq off; read
    chk(s_sym == 2, "R9 sel change waits for next S", s_sym, 2);
    step(1, 0, 0, 0, 0);
    chk(s_sym == 1 && status == 4'b0111, "R8 srdy without irq", {s_sym, status}, 23);
    step(1, 0, 0, 0, 1);
    chk(status[2] == 1, "R7 set wins over read", status[2], 1);
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) == 0, ($urandom % 6) == 0, $urandom % 2,
           ($urandom % 4 == 0) ? 0 : int'($urandom % 6), ($urandom % 7) == 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule